// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block holds the processor status word and updates it after each 8-bit or 16-bit add, subtract or logic operation. The ALU delivers its two operands, the result it produced, the carry (or borrow) out of the active width, a width select and an operation class. From these the block derives the carry, parity, nibble-carry, zero, sign and overflow conditions. It writes them into a 16-bit register that also holds the trap, interrupt-enable and direction controls.

Single-bit strobes set or clear the carry, interrupt-enable and direction bits. A whole-register load path restores the word after it has been popped from the stack. The direction bit is brought out on its own pin for the string-address logic. Every update takes effect on the clock edge that samples the request, so the new word is visible one cycle later.

Top module: `status_flag_unit`

## Requirements
- R1: After reset, `flags` reads 16'h0002: bit 1 is 1 and every other bit is 0.
- R2: For an add (`opClass` = 2'b01), bit 0 (carry) takes `carryOut`. Bit 4 (nibble carry) is set when the low four bits of the operands carry into bit 4. Bit 11 (overflow) is set when the signed sum does not fit the active width. Byte 255+1 sets carry, and byte 100+50 sets overflow.
- R3: For a subtract (`opClass` = 2'b10), bit 0 takes `carryOut` as the borrow out of the top bit. Bit 4 is set on a borrow into bit 4. Bit 11 is set when the signed difference does not fit the active width.
- R4: On an add, subtract or logic update, bit 2 (parity) is 1 when `result[7:0]` holds an even number of ones, whatever the width.
- R5: On an update, bit 6 (zero) is set exactly when the result at the active width is zero. Bit 7 (sign) copies the top bit of the active width. `wideSel` = 1 selects 16 bits and 0 selects 8 bits, with `result[15:8]` ignored.
- R6: A logic update (`opClass` = 2'b11) clears bits 0 and 11, updates bits 2, 6 and 7, and leaves bit 4 unchanged.
- R7: Add, subtract and logic updates never change bit 8 (trap), bit 9 (interrupt enable) or bit 10 (direction).
- R8: `setCarry`/`clrCarry`, `setIntr`/`clrIntr` and `setDir`/`clrDir` force bits 0, 9 and 10. When both strobes of a pair are high, set wins. A carry strobe overrides the carry computed by an update in the same cycle.
- R9: `loadEn` copies `loadData` into the register. Bit 1 is forced to 1, and bits 3, 5 and 15:12 are forced to 0. A load overrides any update or strobe in the same cycle.
- R10: `dirBackward` equals bit 10: 0 means forward processing and 1 means backward.
- R11: With `opClass` = 2'b00 and no strobe or load, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opClass | input | 2 | 00 none, 01 add, 10 subtract, 11 logic |
| wideSel | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| result | input | 16 | ALU result |
| carryOut | input | 1 | Carry (add) or borrow (subtract) out of the active width |
| setCarry | input | 1 | Force carry to 1 |
| clrCarry | input | 1 | Force carry to 0 |
| setIntr | input | 1 | Force interrupt enable to 1 |
| clrIntr | input | 1 | Force interrupt enable to 0 |
| setDir | input | 1 | Force direction to 1 |
| clrDir | input | 1 | Force direction to 0 |
| loadEn | input | 1 | Load the whole register from loadData |
| loadData | input | 16 | Value for the whole-register load |
| flags | output | 16 | Status register |
| dirBackward | output | 1 | Direction bit for the string logic |

## Verification
Two pairs of functions can fall in the same cycle. An arithmetic or logic update can arrive together with a carry or direction strobe, and a whole-register load can arrive together with an update and every strobe. Directed cycles drive each such pair on purpose, including both strobes of a pair at once. A long random run also mixes all inputs freely. A behavioural model forms the expected word on every cycle from plain integer arithmetic and the stated priorities, and compares it with `flags` and `dirBackward`.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  localparam int DATA_W   = 16;
  localparam int NARROW_W = 8;
  localparam int NIB_W    = 4;

  localparam int CF_B  = 0;
  localparam int ONE_B = 1;
  localparam int PF_B  = 2;
  localparam int AF_B  = 4;
  localparam int ZF_B  = 6;
  localparam int SF_B  = 7;
  localparam int TF_B  = 8;
  localparam int IF_B  = 9;
  localparam int DF_B  = 10;
  localparam int OF_B  = 11;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_ADD   = 2'b01,
    OP_SUB   = 2'b10,
    OP_LOGIC = 2'b11
  } opClass_e;

  typedef struct packed {
    logic updArith;
    logic isSub;
    logic updLogic;
    logic loadAll;
    logic cfSet;
    logic cfClr;
    logic ifSet;
    logic ifClr;
    logic dfSet;
    logic dfClr;
  } flagCmd_t;
endpackage

// File: rtl/sflag_ctrl.sv
module sflag_ctrl
  import sflag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] opClass,
  input  logic       setCarry,
  input  logic       clrCarry,
  input  logic       setIntr,
  input  logic       clrIntr,
  input  logic       setDir,
  input  logic       clrDir,
  input  logic       loadEn,
  output flagCmd_t   cmd
);
  opClass_e opSel;
  logic     live;

  assign opSel = opClass_e'(opClass);
  assign live  = !loadEn;

  always_comb begin
    cmd          = '0;
    cmd.loadAll  = loadEn;
    cmd.updArith = live && (opSel == OP_ADD || opSel == OP_SUB);
    cmd.isSub    = opSel == OP_SUB;
    cmd.updLogic = live && (opSel == OP_LOGIC);
    // set beats clear within each pair; load beats everything
    cmd.cfSet    = live && setCarry;
    cmd.cfClr    = live && clrCarry && !setCarry;
    cmd.ifSet    = live && setIntr;
    cmd.ifClr    = live && clrIntr && !setIntr;
    cmd.dfSet    = live && setDir;
    cmd.dfClr    = live && clrDir && !setDir;
  end

  // R9: a load excludes every other action
  p_load_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loadEn |-> !(cmd.updArith || cmd.updLogic || cmd.cfSet || cmd.cfClr ||
                 cmd.ifSet || cmd.ifClr || cmd.dfSet || cmd.dfClr));

  // R8: never both directions on one bit
  p_pair_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd.cfSet, cmd.cfClr}) <= 1 && $countones({cmd.dfSet, cmd.dfClr}) <= 1
    && $countones({cmd.ifSet, cmd.ifClr}) <= 1);
endmodule

// File: rtl/sflag_datapath.sv
module sflag_datapath
  import sflag_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int NW = NARROW_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  flagCmd_t     cmd,
  input  logic         wideSel,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] result,
  input  logic         carryOut,
  input  logic [W-1:0] loadData,
  output logic [W-1:0] flagsQ
);
  localparam logic [W-1:0] WR_MASK = W'((1 << CF_B) | (1 << PF_B) | (1 << AF_B) |
    (1 << ZF_B) | (1 << SF_B) | (1 << TF_B) | (1 << IF_B) | (1 << DF_B) | (1 << OF_B));
  localparam logic [W-1:0] FIX_ONE = W'(1 << ONE_B);
  localparam int NMSB = NW - 1;
  localparam int WMSB = W - 1;

  logic [W-1:0] nxt;
  logic aTop, bTop, rTop, zeroAct, parEven, nibCarry, sOvf;

  always_comb begin
    aTop     = wideSel ? opA[WMSB]    : opA[NMSB];
    bTop     = wideSel ? opB[WMSB]    : opB[NMSB];
    rTop     = wideSel ? result[WMSB] : result[NMSB];
    zeroAct  = wideSel ? (result == '0) : (result[NW-1:0] == '0);
    parEven  = ~^result[NW-1:0];
    nibCarry = opA[NIB_W] ^ opB[NIB_W] ^ result[NIB_W];
    sOvf     = cmd.isSub ? ((aTop != bTop) && (rTop != aTop))
                         : ((aTop == bTop) && (rTop != aTop));
  end

  always_comb begin
    nxt = flagsQ;
    if (cmd.loadAll) begin
      nxt = loadData;
    end else begin
      if (cmd.updArith) begin
        nxt[CF_B] = carryOut;
        nxt[AF_B] = nibCarry;
        nxt[OF_B] = sOvf;
      end
      if (cmd.updLogic) begin
        nxt[CF_B] = 1'b0;
        nxt[OF_B] = 1'b0;
      end
      if (cmd.updArith || cmd.updLogic) begin
        nxt[PF_B] = parEven;
        nxt[ZF_B] = zeroAct;
        nxt[SF_B] = rTop;
      end
      if (cmd.cfSet) nxt[CF_B] = 1'b1;
      if (cmd.cfClr) nxt[CF_B] = 1'b0;
      if (cmd.ifSet) nxt[IF_B] = 1'b1;
      if (cmd.ifClr) nxt[IF_B] = 1'b0;
      if (cmd.dfSet) nxt[DF_B] = 1'b1;
      if (cmd.dfClr) nxt[DF_B] = 1'b0;
    end
    nxt = (nxt & WR_MASK) | FIX_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flagsQ <= FIX_ONE;
    else        flagsQ <= nxt;
  end

  // R7: control bits untouched unless a load or their own strobe
  p_ctrl_bits_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd.loadAll || cmd.ifSet || cmd.ifClr || cmd.dfSet || cmd.dfClr)
    |=> flagsQ[TF_B] == $past(flagsQ[TF_B]) && flagsQ[IF_B] == $past(flagsQ[IF_B])
        && flagsQ[DF_B] == $past(flagsQ[DF_B]));

  // R6: a logic update leaves carry and overflow clear
  p_logic_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.updLogic && !cmd.cfSet |=> !flagsQ[CF_B] && !flagsQ[OF_B]);

  // R9: the register shows the loaded word with fixed bits applied
  p_load_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.loadAll |=> flagsQ == (($past(loadData) & WR_MASK) | FIX_ONE));

  // R11: no request, no change
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == '0 |=> $stable(flagsQ));

  // R8: direction set strobe lands
  p_dir_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.dfSet |=> flagsQ[DF_B]);
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import sflag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  opClass,
  input  logic        wideSel,
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic [15:0] result,
  input  logic        carryOut,
  input  logic        setCarry,
  input  logic        clrCarry,
  input  logic        setIntr,
  input  logic        clrIntr,
  input  logic        setDir,
  input  logic        clrDir,
  input  logic        loadEn,
  input  logic [15:0] loadData,
  output logic [15:0] flags,
  output logic        dirBackward
);
  flagCmd_t cmd;

  sflag_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .opClass(opClass),
    .setCarry(setCarry), .clrCarry(clrCarry),
    .setIntr(setIntr), .clrIntr(clrIntr),
    .setDir(setDir), .clrDir(clrDir),
    .loadEn(loadEn), .cmd(cmd)
  );

  sflag_datapath #(.W(DATA_W), .NW(NARROW_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .wideSel(wideSel),
    .opA(opA), .opB(opB), .result(result), .carryOut(carryOut),
    .loadData(loadData), .flagsQ(flags)
  );

  assign dirBackward = flags[DF_B];
endmodule

// File: tb/status_flag_unit_tb.sv
module status_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  opClass = 2'b00;
  logic        wideSel = 1'b0;
  logic [15:0] opA = '0, opB = '0, result = '0, loadData = '0;
  logic        carryOut = 1'b0;
  logic        setCarry = 1'b0, clrCarry = 1'b0, setIntr = 1'b0, clrIntr = 1'b0;
  logic        setDir = 1'b0, clrDir = 1'b0, loadEn = 1'b0;
  logic [15:0] flags;
  logic        dirBackward;

  int nChecks = 0;
  int nFails  = 0;
  int model   = 32'h0002;
  bit doneFlag = 1'b0;

  always #2.5 clk = ~clk;

  status_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .opClass(opClass), .wideSel(wideSel),
    .opA(opA), .opB(opB), .result(result), .carryOut(carryOut),
    .setCarry(setCarry), .clrCarry(clrCarry), .setIntr(setIntr), .clrIntr(clrIntr),
    .setDir(setDir), .clrDir(clrDir), .loadEn(loadEn), .loadData(loadData),
    .flags(flags), .dirBackward(dirBackward)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int setBit(input int v, input int pos, input bit b);
    return b ? (v | (1 << pos)) : (v & ~(1 << pos));
  endfunction

  // strb = {setC, clrC, setI, clrI, setD, clrD}
  task automatic runCycle(input int cls, input bit wide, input int a, input int b,
                          input bit [5:0] strb, input bit ld, input int ldVal,
                          input string tag);
    int w, mask, r, c, af, ofl, sa, sb, sr, ones;
    w = wide ? 16 : 8;
    mask = (1 << w) - 1;
    a &= mask; b &= mask;
    sa = (a >= (1 << (w - 1))) ? a - (1 << w) : a;
    sb = (b >= (1 << (w - 1))) ? b - (1 << w) : b;
    r = 0; c = 0; af = 0; ofl = 0;
    case (cls)
      1: begin
        r = a + b; c = (r >> w) & 1; r &= mask;
        af = ((a & 15) + (b & 15)) > 15 ? 1 : 0;
        sr = sa + sb;
        ofl = (sr > (1 << (w - 1)) - 1 || sr < -(1 << (w - 1))) ? 1 : 0;
      end
      2: begin
        r = (a - b) & mask; c = (a < b) ? 1 : 0;
        af = ((a & 15) < (b & 15)) ? 1 : 0;
        sr = sa - sb;
        ofl = (sr > (1 << (w - 1)) - 1 || sr < -(1 << (w - 1))) ? 1 : 0;
      end
      3: begin r = a ^ b; c = 1; end
      default: r = a ^ b;
    endcase
    if (ld) begin
      model = (ldVal & 32'h0FD5) | 2;
    end else begin
      if (cls != 0) begin
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        model = setBit(model, 2, (ones % 2) == 0);
        model = setBit(model, 6, r == 0);
        model = setBit(model, 7, ((r >> (w - 1)) & 1) == 1);
        if (cls == 3) begin
          model = setBit(model, 0, 0);
          model = setBit(model, 11, 0);
        end else begin
          model = setBit(model, 0, c == 1);
          model = setBit(model, 4, af == 1);
          model = setBit(model, 11, ofl == 1);
        end
      end
      if (strb[5]) model = setBit(model, 0, 1); else if (strb[4]) model = setBit(model, 0, 0);
      if (strb[3]) model = setBit(model, 9, 1); else if (strb[2]) model = setBit(model, 9, 0);
      if (strb[1]) model = setBit(model, 10, 1); else if (strb[0]) model = setBit(model, 10, 0);
    end
    opClass  = 2'(cls);
    wideSel  = wide;
    opA      = 16'(a) | (wide ? 16'h0000 : 16'h3C00);
    opB      = 16'(b) | (wide ? 16'h0000 : 16'hC300);
    result   = 16'(r) | (wide ? 16'h0000 : 16'hA500);
    carryOut = c[0];
    {setCarry, clrCarry, setIntr, clrIntr, setDir, clrDir} = strb;
    loadEn   = ld;
    loadData = 16'(ldVal);
    @(posedge clk);
    @(negedge clk);
    check(tag, int'(flags), model);
    check("R10 dirBackward", int'(dirBackward), (model >> 10) & 1);
    opClass = 2'b00;
    {setCarry, clrCarry, setIntr, clrIntr, setDir, clrDir} = '0;
    loadEn = 1'b0;
  endtask

  initial begin
    #(5ns * 150000);
    if (!doneFlag) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset value", int'(flags), 32'h0002);
    runCycle(1, 0, 255, 1, 6'b0, 0, 0, "R2 byte 255+1 carry");
    runCycle(1, 0, 100, 50, 6'b0, 0, 0, "R2 byte 100+50 overflow");
    runCycle(1, 1, 16'h7FFF, 1, 6'b0, 0, 0, "R5 word sign and overflow");
    runCycle(2, 0, 8'h10, 8'h01, 6'b0, 0, 0, "R3 nibble borrow");
    runCycle(2, 0, 0, 1, 6'b0, 0, 0, "R3 byte borrow");
    runCycle(2, 1, 16'h8000, 1, 6'b0, 0, 0, "R3 word signed overflow");
    runCycle(1, 1, 16'h0100, 16'h0200, 6'b0, 0, 0, "R4 parity low byte only");
    runCycle(1, 0, 8'h80, 8'h80, 6'b0, 0, 0, "R5 byte zero ignores upper");
    runCycle(0, 0, 0, 0, 6'b100000, 0, 0, "R8 set carry");
    runCycle(3, 1, 16'h00F0, 16'h0F0F, 6'b0, 0, 0, "R6 logic clears carry overflow");
    runCycle(0, 0, 0, 0, 6'b000011, 0, 0, "R8 dir set wins over clear");
    runCycle(1, 0, 255, 1, 6'b010000, 0, 0, "R8 clear carry beats update");
    runCycle(0, 0, 0, 0, 6'b001100, 0, 0, "R8 intr set wins");
    runCycle(1, 1, 16'h1234, 16'h4321, 6'b0, 0, 0, "R7 update keeps control bits");
    runCycle(0, 0, 0, 0, 6'b000001, 0, 0, "R10 direction forward");
    runCycle(0, 0, 0, 0, 6'b0, 1, 16'hFFFF, "R9 load all ones");
    runCycle(2, 1, 5, 9, 6'b111111, 1, 16'h0000, "R9 load overrides all");
    runCycle(0, 0, 0, 0, 6'b0, 1, 16'h0100, "R9 load trap");
    runCycle(2, 0, 3, 200, 6'b0, 0, 0, "R7 trap kept by subtract");
    runCycle(0, 1, 16'hFFFF, 16'h0001, 6'b0, 0, 0, "R11 no class no change");
    for (int k = 0; k < 400; k++) begin
      int cls, a, b, s, l;
      cls = int'($urandom_range(0, 3));
      a = int'($urandom_range(0, 65535));
      b = int'($urandom_range(0, 65535));
      s = int'($urandom_range(0, 63));
      l = ($urandom_range(0, 15) == 0) ? 1 : 0;
      if ($urandom_range(0, 1) == 0) s = 0;
      runCycle(cls, $urandom_range(0, 1) == 1, a, b, 6'(s), l == 1,
               int'($urandom_range(0, 65535)), "R2 R3 R6 R8 random mix");
    end
    doneFlag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule